// File: doc/BRIEF.md
# Pulse-Programmed Trim Register

This block holds a 5-bit trim setting that is programmed over one serial line, with no bus. Each pulse on that line acts as a command, and the number of clock cycles the line stays high decides which command it is. A mid-length pulse erases the working code and opens an editing session. A short pulse steps the working code up by one and wraps from 31 back to 0. A long pulse commits the working code to a retained register. Pulses that are too brief to count as a step are treated as noise and dropped.

Programming is possible only while the program-enable input is high. While a session is open the output shows the working code, so the effect of each step can be seen directly. When the session closes, any uncommitted work is thrown away and the output shows the retained value again. That retained value changes only through a store pulse and is kept across sessions.

Top module: `pulse_trim_reg`

## Requirements
- R1: After synchronous reset, `trim_code` equals the parameter `RESET_CODE` (default 16) and `stored_flag` is 0.
- R2: A pulse's width is the number of rising clock edges at which `data_in` is sampled high. A pulse acts at the first edge at which `data_in` is sampled low. A pulse narrower than `STEP_MIN` (default 4) has no effect.
- R3: A pulse of width `ERASE_MIN` to `STORE_MIN-1` (default 16 to 63) is an erase. It sets the working code to 0 and opens a session. While `prog_en` is high and a session is open, `trim_code` shows the working code.
- R4: A pulse of width `STEP_MIN` to `ERASE_MIN-1` (default 4 to 15) in an open session raises the working code by exactly 1.
- R5: A step pulse applied while the working code is 31 sets it to 0.
- R6: Step and store pulses received while `prog_en` is high but before any erase in that session have no effect.
- R7: A pulse of width `STORE_MIN` or more (default 64, widths beyond this saturate) in an open session copies the working code into the retained register and sets `stored_flag` to 1.
- R8: While `prog_en` is low, pulses have no effect, and `trim_code` shows the retained value. A pulse that is still high when `prog_en` falls is discarded.
- R9: When `prog_en` goes low, the session closes and any uncommitted working code is lost. After `prog_en` rises again, `trim_code` shows the retained value until the next erase.
- R10: The retained value and `stored_flag` stay unchanged through the end of a session and change only on a store pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_en | input | 1 | Programming permitted while high |
| data_in | input | 1 | Command pulse line, synchronous to clk |
| trim_code | output | 5 | Working code during an open session, retained code otherwise |
| stored_flag | output | 1 | High once a store has committed a value |

## Verification
The bench sends pulses whose widths sit exactly on each class boundary: 3 and 4 cycles, 15 and 16 cycles, and 63 and 64 cycles. An off-by-one in the width counter or the comparators would show up as a dropped step or as a step mistaken for an erase. It steps the code through the full wrap from 31 to 0, which a counter with a wrong width or a clamp would miss. It also sends step and store pulses before any erase, which a design without a session gate would act on. Finally, it lowers `prog_en` both mid-session and mid-pulse. A design that kept uncommitted work, or that finished a cut-off pulse, would then show the wrong retained value.

// File: rtl/trim_pkg.sv
// Package: shared command encoding for the pulse-programmed trim register.
// Assumes: one command at most per clock cycle.
package trim_pkg;
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_ERASE = 2'd2,
        CMD_STORE = 2'd3
    } trim_cmd_e;
endpackage

// File: rtl/trim_pulse_classifier.sv
// Module: measures how long data_in stays high and, on the falling edge,
// issues one command chosen by width class.
// Assumes: data_in is already synchronous to clk; STEP_MIN >= 1 and
// STEP_MIN < ERASE_MIN < STORE_MIN. The width count saturates at STORE_MIN.
module trim_pulse_classifier
    import trim_pkg::*;
#(
    parameter int STEP_MIN  = 4,
    parameter int ERASE_MIN = 16,
    parameter int STORE_MIN = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      prog_en,
    input  logic      data_in,
    output trim_cmd_e cmd
);
    localparam int CNT_W = $clog2(STORE_MIN + 1);
    localparam logic [CNT_W-1:0] W_STEP  = CNT_W'(STEP_MIN);
    localparam logic [CNT_W-1:0] W_ERASE = CNT_W'(ERASE_MIN);
    localparam logic [CNT_W-1:0] W_STORE = CNT_W'(STORE_MIN);

    logic [CNT_W-1:0] width_q;

    // Count the cycles of high time; clear when low, disabled or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !prog_en) begin
            width_q <= '0;
        end else if (data_in) begin
            if (width_q != W_STORE) width_q <= width_q + 1'b1;
        end else begin
            width_q <= '0;
        end
    end

    // Decode the finished pulse into a command in the cycle the line reads low.
    always_comb begin
        cmd = CMD_NONE;
        if (prog_en && !data_in) begin
            if (width_q >= W_STORE)      cmd = CMD_STORE;
            else if (width_q >= W_ERASE) cmd = CMD_ERASE;
            else if (width_q >= W_STEP)  cmd = CMD_STEP;
        end
    end

    initial begin
        a_r2_param_order: assert (STEP_MIN >= 1 && STEP_MIN < ERASE_MIN && ERASE_MIN < STORE_MIN)
            else $error("width thresholds out of order");
    end

    // R2: a pulse produces a single command, never two in a row
    a_r2_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NONE) |=> (cmd == CMD_NONE));
    // R8: nothing is issued while programming is disabled
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |-> (cmd == CMD_NONE));
endmodule

// File: rtl/trim_session.sv
// Module: holds the working code of a programming session. An erase clears it
// and opens the session; steps increment it with wrap; a store is forwarded
// as a request. Closing prog_en discards the session.
// Assumes: cmd comes from trim_pulse_classifier and is already gated by prog_en.
module trim_session
    import trim_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  trim_cmd_e         cmd,
    output logic [CODE_W-1:0] work_code,
    output logic              armed,
    output logic              store_req
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    // Track the open session and apply erase and step commands to the working code.
    always_ff @(posedge clk) begin
        if (!rst_n || !prog_en) begin
            armed     <= 1'b0;
            work_code <= '0;
        end else begin
            unique case (cmd)
                CMD_ERASE: begin
                    armed     <= 1'b1;
                    work_code <= '0;
                end
                CMD_STEP: begin
                    if (armed) work_code <= work_code + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Only an open session may commit its code.
    assign store_req = armed && (cmd == CMD_STORE);

    // R3: an erase leaves a zero code and an open session
    a_r3_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ERASE) |=> (armed && work_code == '0));
    // R4: a step below the top value adds exactly one
    a_r4_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && armed && work_code != CODE_MAX) |=> (work_code == $past(work_code) + 1'b1));
    // R5: a step at the top value returns to zero
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && armed && work_code == CODE_MAX) |=> (work_code == '0));
    // R6: a step outside an open session leaves the code alone
    a_r6_step_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && !armed && prog_en) |=> (!armed && $stable(work_code)));
    // R9: closing programming discards the session
    a_r9_discard: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> (!armed && work_code == '0));
endmodule

// File: rtl/trim_retain.sv
// Module: retained trim register and its valid flag; loads only on a store request.
// Assumes: store_req lasts one cycle per store pulse.
module trim_retain #(
    parameter int                CODE_W     = 5,
    parameter logic [CODE_W-1:0] RESET_CODE = 5'd16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic [CODE_W-1:0] work_code,
    output logic [CODE_W-1:0] kept_code,
    output logic              kept_valid
);
    // Commit the working code on a store; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept_code  <= RESET_CODE;
            kept_valid <= 1'b0;
        end else if (store_req) begin
            kept_code  <= work_code;
            kept_valid <= 1'b1;
        end
    end

    // R7: a store copies the working code and raises the flag
    a_r7_commit: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> (kept_code == $past(work_code) && kept_valid));
    // R10: without a store the retained value and flag do not move
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !store_req |=> ($stable(kept_code) && $stable(kept_valid)));
endmodule

// File: rtl/pulse_trim_reg.sv
// Module: top of the pulse-programmed trim register. Chains classifier,
// session and retained register, and picks which code appears on trim_code.
// Assumes: data_in and prog_en are synchronous to clk.
module pulse_trim_reg
    import trim_pkg::*;
#(
    parameter int                CODE_W     = 5,
    parameter logic [CODE_W-1:0] RESET_CODE = 5'd16,
    parameter int                STEP_MIN   = 4,
    parameter int                ERASE_MIN  = 16,
    parameter int                STORE_MIN  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              data_in,
    output logic [CODE_W-1:0] trim_code,
    output logic              stored_flag
);
    trim_cmd_e         cmd;
    logic [CODE_W-1:0] work_code;
    logic [CODE_W-1:0] kept_code;
    logic              armed;
    logic              store_req;

    trim_pulse_classifier #(
        .STEP_MIN (STEP_MIN),
        .ERASE_MIN(ERASE_MIN),
        .STORE_MIN(STORE_MIN)
    ) u_class (
        .clk    (clk),
        .rst_n  (rst_n),
        .prog_en(prog_en),
        .data_in(data_in),
        .cmd    (cmd)
    );

    trim_session #(
        .CODE_W(CODE_W)
    ) u_sess (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .cmd      (cmd),
        .work_code(work_code),
        .armed    (armed),
        .store_req(store_req)
    );

    trim_retain #(
        .CODE_W    (CODE_W),
        .RESET_CODE(RESET_CODE)
    ) u_keep (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_req (store_req),
        .work_code (work_code),
        .kept_code (kept_code),
        .kept_valid(stored_flag)
    );

    // Show the working code during an open session, else the retained code.
    assign trim_code = (prog_en && armed) ? work_code : kept_code;

    // R8: with programming off the output is the retained code
    a_r8_off_shows_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |-> (trim_code == kept_code));
endmodule

// File: tb/pulse_trim_reg_tb.sv
module pulse_trim_reg_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b0;
    logic       data_in = 1'b0;
    logic [4:0] trim_code;
    logic       stored_flag;

    int checks = 0;
    int failures = 0;

    pulse_trim_reg u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_en),
        .data_in    (data_in),
        .trim_code  (trim_code),
        .stored_flag(stored_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [4:0] exp_code, input logic exp_flag);
        checks++;
        if (trim_code !== exp_code || stored_flag !== exp_flag) begin
            failures++;
            $display("FAIL %s: code=%0d flag=%0b expected code=%0d flag=%0b",
                     req, trim_code, stored_flag, exp_code, exp_flag);
        end
    endtask

    // High for w sampled edges, then low; returns at the negedge after the acting edge.
    task automatic pulse(input int w);
        @(negedge clk);
        data_in = 1'b1;
        repeat (w) @(negedge clk);
        data_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        prog_en = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", 5'd16, 1'b0);
    endtask

    task automatic t_disabled;
        pulse(20);
        check("R8 erase while disabled", 5'd16, 1'b0);
        pulse(70);
        check("R8 store while disabled", 5'd16, 1'b0);
    endtask

    task automatic t_before_erase;
        set_en(1'b1);
        check("R9 enable shows retained", 5'd16, 1'b0);
        pulse(8);
        check("R6 step before erase", 5'd16, 1'b0);
        pulse(70);
        check("R6 store before erase", 5'd16, 1'b0);
    endtask

    task automatic t_widths;
        pulse(2);
        check("R2 glitch ignored", 5'd16, 1'b0);
        pulse(20);
        check("R3 erase clears", 5'd0, 1'b0);
        pulse(3);
        check("R2 width 3 ignored", 5'd0, 1'b0);
        pulse(4);
        check("R4 width 4 steps", 5'd1, 1'b0);
        pulse(15);
        check("R4 width 15 steps", 5'd2, 1'b0);
        pulse(16);
        check("R3 width 16 erases", 5'd0, 1'b0);
        pulse(63);
        check("R3 width 63 erases", 5'd0, 1'b0);
    endtask

    task automatic t_wrap_store;
        for (int i = 0; i < 31; i++) pulse(5);
        check("R5 reach 31", 5'd31, 1'b0);
        pulse(5);
        check("R5 wrap to 0", 5'd0, 1'b0);
        for (int i = 0; i < 7; i++) pulse(6);
        pulse(64);
        check("R7 store width 64", 5'd7, 1'b1);
        pulse(200);
        check("R7 saturating store", 5'd7, 1'b1);
    endtask

    task automatic t_discard;
        pulse(5);
        pulse(5);
        check("R4 steps after store", 5'd9, 1'b1);
        set_en(1'b0);
        check("R9 unstored work lost", 5'd7, 1'b1);
        set_en(1'b1);
        check("R9 reenable shows retained", 5'd7, 1'b1);
        pulse(5);
        check("R6 step in new session before erase", 5'd7, 1'b1);
        pulse(20);
        pulse(5);
        check("R3 new session working code", 5'd1, 1'b1);
        set_en(1'b0);
        check("R10 retained survives session end", 5'd7, 1'b1);
    endtask

    task automatic t_abort;
        set_en(1'b1);
        pulse(20);
        @(negedge clk);
        data_in = 1'b1;
        repeat (70) @(negedge clk);
        prog_en = 1'b0;
        @(negedge clk);
        data_in = 1'b0;
        @(negedge clk);
        check("R8 pulse cut by disable", 5'd7, 1'b1);
        set_en(1'b1);
        check("R10 retained after cut pulse", 5'd7, 1'b1);
        set_en(1'b0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_before_erase();
        t_widths();
        t_wrap_store();
        t_discard();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule